// File: doc/BRIEF.md
# Single-Cycle Chained-ALU Processor Core

This core executes three compound instructions, each in one clock cycle. Every instruction links two ALU operations around the data memory. The first ALU works on the `rs` register. It either passes that value through to form a data-memory address, or shifts it left. The second ALU takes the loaded word, the first ALU's result or the `rt` register, and combines it with `rt` or a sign-extended immediate. Its result either goes into the register file or becomes the data written to memory.

The instruction memory and data memory are separate arrays inside the core. Each has a synchronous write and a combinational read. While `load_en` is high, the program counter is frozen and the core writes nothing. During that time a testbench or loader uses the load port to fill either array, one word per cycle. It can inspect any register or data word through the two peek ports. When `load_en` falls, the core fetches from address 0 after reset and retires one instruction per clock.

All instructions use one 32-bit layout:
- opcode in bits 31..26
- rs in bits 25..21
- rt in bits 20..16
- rd in bits 15..11
- an 11-bit immediate in bits 10..0

Top module: `chain_core`

## Requirements
- R1: Holding `rst_n` low at a rising edge sets `pc` to 0 and clears all 32 registers to zero.
- R2: At every rising edge with `rst_n` high and `load_en` low, `pc` increases by 4. At every rising edge with `load_en` high, `pc` keeps its value.
- R3: Opcode 6'h01 (load-and-add) writes register rd with the data word at address R[rs], plus R[rt]. It writes no memory.
- R4: Opcode 6'h02 (add-and-store) writes R[rt] plus the sign-extended 11-bit immediate to the data word at address R[rs]. It writes no register.
- R5: Opcode 6'h03 (shift-and-add) writes register rd with R[rs] shifted left by immediate bits 4..0, plus R[rt]. Immediate bits 10..5 do not affect the result.
- R6: Every opcode other than 6'h01, 6'h02 and 6'h03 writes neither a register nor memory.
- R7: Register 0 always reads as zero, including after an instruction names it as rd, and when it is used as a source.
- R8: The decode outputs `{ctl_reg_we, ctl_mem_we, ctl_mem_re}` for the word at `pc` are 3'b101 for load-and-add, 3'b010 for add-and-store, 3'b100 for shift-and-add and 3'b000 for any other opcode.
- R9: An instruction sees the register and memory results of the instruction retired in the cycle before it.
- R10: While `load_en` is high, the core writes no register and no memory. A rising edge with `load_en` high stores `load_data` at word `load_word`: in data memory if `load_to_dmem` is 1, in instruction memory if it is 0.
- R11: Both memories are word-addressed with byte-address bits [N+1:2]. Address bits 1..0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Freezes the core and enables the load port |
| load_to_dmem | input | 1 | Load target: 1 selects data memory, 0 selects instruction memory |
| load_word | input | LDW (6) | Word index for the load write |
| load_data | input | 32 | Word to store through the load port |
| peek_reg | input | 5 | Register index to observe |
| peek_reg_data | output | 32 | Value of the register named by `peek_reg` |
| peek_word | input | DAW (6) | Data-memory word index to observe |
| peek_word_data | output | 32 | Data-memory word named by `peek_word` |
| pc | output | 32 | Program counter (byte address) |
| ctl_reg_we | output | 1 | Decoded register-write control for the current word |
| ctl_mem_we | output | 1 | Decoded memory-write control for the current word |
| ctl_mem_re | output | 1 | Decoded memory-read control for the current word |

## Verification
The decode outputs and both peek ports are combinational, so they are valid in the same cycle the bench drives `peek_reg`, `peek_word` or the imem word at `pc`. Every instruction retires at the rising edge that ends its cycle. The bench therefore lowers `load_en` at a falling edge and lets exactly N rising edges pass. It raises `load_en` again at the next falling edge and only then reads registers and memory. At that point `pc` must equal the start value plus 4·N. All observations are taken 1 ns after a falling edge, half a period clear of the next rising edge.

// File: rtl/cc_pkg.sv
// Shared types for the chained-ALU core: instruction layout, ALU
// operation codes, operand-select encodings and the control bundle.
// Assumes a fixed 32-bit instruction word.
package cc_pkg;

    localparam int XLEN = 32;

    localparam logic [5:0] OP_LDADD = 6'h01;
    localparam logic [5:0] OP_ADDST = 6'h02;
    localparam logic [5:0] OP_SHADD = 6'h03;

    typedef enum logic [2:0] {
        ALU_ADD    = 3'd0,
        ALU_SUB    = 3'd1,
        ALU_SLL    = 3'd2,
        ALU_PASS_A = 3'd3,
        ALU_PASS_B = 3'd4
    } alu_op_e;

    // Upper operand of the second ALU
    typedef enum logic [1:0] {
        A2_MEM  = 2'd0,
        A2_ALU1 = 2'd1,
        A2_RT   = 2'd2
    } a2_sel_e;

    typedef struct packed {
        logic [5:0]  op;
        logic [4:0]  rs;
        logic [4:0]  rt;
        logic [4:0]  rd;
        logic [10:0] imm;
    } instr_t;

    typedef struct packed {
        logic    reg_we;
        logic    mem_we;
        logic    mem_re;
        alu_op_e alu1_op;
        alu_op_e alu2_op;
        logic    b1_shamt;   // 1: ALU1 lower operand is imm[4:0], 0: R[rt]
        a2_sel_e a2_sel;
        logic    b2_imm;     // 1: ALU2 lower operand is sign-extended imm, 0: R[rt]
    } ctrl_t;

endpackage

// File: rtl/cc_alu.sv
// Combinational ALU with five operations. Shift amount is taken from
// the low log2(W) bits of operand b. Assumes W is a power of two.
module cc_alu
    import cc_pkg::*;
#(
    parameter int W = 32,
    localparam int SHW = $clog2(W)
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);

    // Select the result for the requested operation
    always_comb begin
        unique case (op)
            ALU_ADD:    y = a + b;
            ALU_SUB:    y = a - b;
            ALU_SLL:    y = a << b[SHW-1:0];
            ALU_PASS_A: y = a;
            ALU_PASS_B: y = b;
            default:    y = '0;
        endcase
    end

endmodule

// File: rtl/cc_decode.sv
// Opcode decoder. Produces the full control bundle for one instruction;
// unknown opcodes yield an all-zero bundle (no write of any kind).
// Don't-care fields are set so that no instruction waits on an
// unneeded path (address comes straight through ALU1 as PASS_A).
module cc_decode
    import cc_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctl
);

    // Map each opcode to its control settings
    always_comb begin
        ctl = '0;
        unique case (opcode)
            OP_LDADD: begin
                ctl.reg_we   = 1'b1;
                ctl.mem_re   = 1'b1;
                ctl.alu1_op  = ALU_PASS_A;
                ctl.b1_shamt = 1'b0;
                ctl.alu2_op  = ALU_ADD;
                ctl.a2_sel   = A2_MEM;
                ctl.b2_imm   = 1'b0;
            end
            OP_ADDST: begin
                ctl.mem_we   = 1'b1;
                ctl.alu1_op  = ALU_PASS_A;
                ctl.b1_shamt = 1'b0;
                ctl.alu2_op  = ALU_ADD;
                ctl.a2_sel   = A2_RT;
                ctl.b2_imm   = 1'b1;
            end
            OP_SHADD: begin
                ctl.reg_we   = 1'b1;
                ctl.alu1_op  = ALU_SLL;
                ctl.b1_shamt = 1'b1;
                ctl.alu2_op  = ALU_ADD;
                ctl.a2_sel   = A2_ALU1;
                ctl.b2_imm   = 1'b0;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/cc_regfile.sv
// Register file: NREG words of W bits, NRD combinational read ports,
// one synchronous write port. Entry 0 is never written and reads zero.
// Synchronous active-low reset clears every entry.
module cc_regfile #(
    parameter int W    = 32,
    parameter int NREG = 32,
    parameter int NRD  = 3,
    localparam int AW  = $clog2(NREG)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [W-1:0]            wdata,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output logic [NRD-1:0][W-1:0]   rdata
);

    logic [W-1:0] regs [NREG];

    // Clear on reset, otherwise store the write-port word (entry 0 excluded)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        // Read port g, forcing zero for entry 0
        always_comb rdata[g] = (raddr[g] == '0) ? '0 : regs[raddr[g]];
    end

    AST_RF_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr != '0) |=> (regs[$past(waddr)] == $past(wdata))); // R3

endmodule

// File: rtl/cc_ram.sv
// Word array with one synchronous write port and NRD combinational
// read ports. No reset; contents are defined by writes only.
// Assumes WORDS is a power of two.
module cc_ram #(
    parameter int W     = 32,
    parameter int WORDS = 64,
    parameter int NRD   = 1,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [W-1:0]            wdata,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output logic [NRD-1:0][W-1:0]   rdata
);

    logic [W-1:0] mem [WORDS];

    // Store the write-port word
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        // Read port g
        always_comb rdata[g] = mem[raddr[g]];
    end

    AST_RAM_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(waddr)] == $past(wdata))); // R4

endmodule

// File: rtl/chain_core.sv
// Single-cycle core running three compound instructions, each chaining
// two ALU operations around the data memory. Holds PC and suppresses
// all core writes while load_en is high; the load port then fills
// instruction or data memory. Peek ports read registers and data words.
// Assumes both memory depths are powers of two.
module chain_core
    import cc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS),
    localparam int LDW = (IAW > DAW) ? IAW : DAW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic             load_to_dmem,
    input  logic [LDW-1:0]   load_word,
    input  logic [XLEN-1:0]  load_data,
    input  logic [4:0]       peek_reg,
    output logic [XLEN-1:0]  peek_reg_data,
    input  logic [DAW-1:0]   peek_word,
    output logic [XLEN-1:0]  peek_word_data,
    output logic [XLEN-1:0]  pc,
    output logic             ctl_reg_we,
    output logic             ctl_mem_we,
    output logic             ctl_mem_re
);

    localparam int SIMM_EXT = XLEN - 11;

    instr_t             instr;
    ctrl_t              ctl;
    logic               run;
    logic [XLEN-1:0]    rs_val, rt_val, simm, shamt;
    logic [XLEN-1:0]    alu1_b, alu1_y, alu2_a, alu2_b, alu2_y;
    logic [XLEN-1:0]    dm_rd;
    logic               rf_we, dm_core_we;

    logic               im_we;
    logic [0:0][IAW-1:0]  im_raddr;
    logic [0:0][XLEN-1:0] im_rdata;

    logic               dm_we;
    logic [DAW-1:0]     dm_waddr;
    logic [XLEN-1:0]    dm_wdata;
    logic [1:0][DAW-1:0]  dm_raddr;
    logic [1:0][XLEN-1:0] dm_rdata;

    logic [2:0][4:0]      rf_raddr;
    logic [2:0][XLEN-1:0] rf_rdata;

    // Program counter: reset to 0, step by 4 while running
    always_ff @(posedge clk) begin
        if (!rst_n)        pc <= '0;
        else if (!load_en) pc <= pc + 32'd4;
    end

    assign run = rst_n && !load_en;

    // Instruction fetch
    assign im_we       = load_en && !load_to_dmem;
    assign im_raddr[0] = pc[IAW+1:2];
    assign instr       = instr_t'(im_rdata[0]);

    cc_ram #(.W(XLEN), .WORDS(IMEM_WORDS), .NRD(1)) u_imem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (im_we),
        .waddr (load_word[IAW-1:0]),
        .wdata (load_data),
        .raddr (im_raddr),
        .rdata (im_rdata)
    );

    cc_decode u_dec (
        .opcode (instr.op),
        .ctl    (ctl)
    );

    assign ctl_reg_we = ctl.reg_we;
    assign ctl_mem_we = ctl.mem_we;
    assign ctl_mem_re = ctl.mem_re;

    // Register file: port 0 rs, port 1 rt, port 2 peek
    assign rf_raddr[0] = instr.rs;
    assign rf_raddr[1] = instr.rt;
    assign rf_raddr[2] = peek_reg;
    assign rs_val        = rf_rdata[0];
    assign rt_val        = rf_rdata[1];
    assign peek_reg_data = rf_rdata[2];
    assign rf_we         = run && ctl.reg_we;

    cc_regfile #(.W(XLEN), .NREG(32), .NRD(3)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (instr.rd),
        .wdata (alu2_y),
        .raddr (rf_raddr),
        .rdata (rf_rdata)
    );

    // Immediate forms: sign-extended addend and 5-bit shift amount
    assign simm  = {{SIMM_EXT{instr.imm[10]}}, instr.imm};
    assign shamt = {{(XLEN-5){1'b0}}, instr.imm[4:0]};

    // First ALU lower-operand select
    always_comb alu1_b = ctl.b1_shamt ? shamt : rt_val;

    cc_alu #(.W(XLEN)) u_alu1 (
        .op (ctl.alu1_op),
        .a  (rs_val),
        .b  (alu1_b),
        .y  (alu1_y)
    );

    // Data memory: core write unless loading; port 0 core, port 1 peek
    assign dm_core_we  = run && ctl.mem_we;
    assign dm_raddr[0] = alu1_y[DAW+1:2];
    assign dm_raddr[1] = peek_word;
    assign dm_rd          = dm_rdata[0];
    assign peek_word_data = dm_rdata[1];

    // Data-memory write-port source select
    always_comb begin
        if (load_en) begin
            dm_we    = load_to_dmem;
            dm_waddr = load_word[DAW-1:0];
            dm_wdata = load_data;
        end else begin
            dm_we    = dm_core_we;
            dm_waddr = alu1_y[DAW+1:2];
            dm_wdata = alu2_y;
        end
    end

    cc_ram #(.W(XLEN), .WORDS(DMEM_WORDS), .NRD(2)) u_dmem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (dm_we),
        .waddr (dm_waddr),
        .wdata (dm_wdata),
        .raddr (dm_raddr),
        .rdata (dm_rdata)
    );

    // Second ALU operand selects
    always_comb begin
        unique case (ctl.a2_sel)
            A2_MEM:  alu2_a = dm_rd;
            A2_ALU1: alu2_a = alu1_y;
            A2_RT:   alu2_a = rt_val;
            default: alu2_a = '0;
        endcase
        alu2_b = ctl.b2_imm ? simm : rt_val;
    end

    cc_alu #(.W(XLEN)) u_alu2 (
        .op (ctl.alu2_op),
        .a  (alu2_a),
        .b  (alu2_b),
        .y  (alu2_y)
    );

    AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> (pc == $past(pc) + 32'd4)); // R2

    AST_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> $stable(pc)); // R10

    AST_NOOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (instr.op != OP_LDADD && instr.op != OP_ADDST && instr.op != OP_SHADD)
        |-> (!rf_we && !dm_core_we)); // R6

    AST_R0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (peek_reg == 5'd0) |-> (peek_reg_data == '0)); // R7

endmodule

// File: tb/tb_chain_core.sv
module tb_chain_core;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        load_en;
    logic        load_to_dmem;
    logic [5:0]  load_word;
    logic [31:0] load_data;
    logic [4:0]  peek_reg;
    logic [31:0] peek_reg_data;
    logic [5:0]  peek_word;
    logic [31:0] peek_word_data;
    logic [31:0] pc;
    logic        ctl_reg_we, ctl_mem_we, ctl_mem_re;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    chain_core dut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_to_dmem(load_to_dmem),
        .load_word(load_word), .load_data(load_data),
        .peek_reg(peek_reg), .peek_reg_data(peek_reg_data),
        .peek_word(peek_word), .peek_word_data(peek_word_data),
        .pc(pc), .ctl_reg_we(ctl_reg_we), .ctl_mem_we(ctl_mem_we), .ctl_mem_re(ctl_mem_re)
    );

    function automatic logic [31:0] enc(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [4:0] rd,
                                        input logic [10:0] imm);
        return {op, rs, rt, rd, imm};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        load_en = 1'b1; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic put(input logic to_d, input int idx, input logic [31:0] w);
        load_en = 1'b1; load_to_dmem = to_d;
        load_word = 6'(idx); load_data = w;
        @(negedge clk);
    endtask

    task automatic clear_mems();
        for (int i = 0; i < 64; i++) put(1'b0, i, 32'h0);
        for (int i = 0; i < 64; i++) put(1'b1, i, 32'h0);
    endtask

    task automatic run(input int n);
        load_en = 1'b0;
        repeat (n) @(negedge clk);
        load_en = 1'b1;
    endtask

    task automatic rd_reg(input int idx, output logic [31:0] v);
        peek_reg = 5'(idx); #1; v = peek_reg_data;
    endtask

    task automatic rd_mem(input int idx, output logic [31:0] v);
        peek_word = 6'(idx); #1; v = peek_word_data;
    endtask

    task automatic t_ldadd();
        logic [31:0] v;
        do_reset(); clear_mems();
        put(1, 0, 32'd8); put(1, 2, 32'd1000); put(1, 4, 32'd11);
        put(0, 0, enc(6'h01, 0, 0, 1, 0));
        put(0, 1, enc(6'h01, 1, 1, 2, 0));
        put(0, 2, enc(6'h01, 1, 2, 3, 0));
        put(0, 3, enc(6'h03, 1, 0, 6, 1));
        put(0, 4, enc(6'h01, 6, 0, 5, 0));
        put(0, 5, enc(6'h01, 5, 0, 7, 0));
        run(6);
        check("R2 pc after 6 steps", pc, 32'd24);
        rd_reg(1, v); check("R3 r1 load", v, 32'd8);
        rd_reg(2, v); check("R3 r2 load plus rt", v, 32'd1008);
        rd_reg(3, v); check("R9 r3 uses prior result", v, 32'd2008);
        rd_reg(5, v); check("R3 r5 load", v, 32'd11);
        rd_reg(7, v); check("R11 low address bits ignored", v, 32'd1000);
        rd_mem(0, v); check("R3 no store word0", v, 32'd8);
        rd_mem(2, v); check("R3 no store word2", v, 32'd1000);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        int nz = 0;
        do_reset(); #1;
        check("R1 pc reset", pc, 32'd0);
        for (int i = 0; i < 32; i++) begin
            rd_reg(i, v);
            if (v !== 32'd0) nz++;
        end
        check("R1 registers nonzero after reset", 32'(nz), 32'd0);
    endtask

    task automatic t_addst();
        logic [31:0] v;
        do_reset(); clear_mems();
        put(1, 0, 32'd4); put(1, 1, 32'd7);
        put(0, 0, enc(6'h01, 0, 0, 1, 0));
        put(0, 1, enc(6'h01, 1, 0, 2, 0));
        put(0, 2, enc(6'h03, 1, 0, 4, 3));
        put(0, 3, enc(6'h02, 4, 2, 9, 11'd5));
        put(0, 4, enc(6'h02, 1, 2, 9, 11'h7F6));
        put(0, 5, enc(6'h01, 4, 0, 10, 0));
        run(6);
        rd_mem(8, v); check("R4 store rt+imm", v, 32'd12);
        rd_mem(1, v); check("R4 negative immediate", v, 32'hFFFF_FFFD);
        rd_reg(9, v); check("R4 no register write", v, 32'd0);
        rd_reg(2, v); check("R4 rt unchanged", v, 32'd7);
        rd_reg(10, v); check("R9 load of stored word", v, 32'd12);
    endtask

    task automatic t_shadd();
        logic [31:0] v;
        do_reset(); clear_mems();
        put(1, 0, 32'd3);
        put(0, 0, enc(6'h01, 0, 0, 1, 0));
        put(0, 1, enc(6'h03, 1, 1, 2, 11'd2));
        put(0, 2, enc(6'h03, 1, 0, 3, 11'h7E5));
        put(0, 3, enc(6'h03, 1, 0, 4, 11'd31));
        put(0, 4, enc(6'h03, 1, 1, 0, 11'd1));
        put(0, 5, enc(6'h03, 0, 1, 5, 11'd4));
        put(0, 6, enc(6'h03, 2, 0, 6, 11'd1));
        run(7);
        rd_reg(2, v); check("R5 shift plus rt", v, 32'd15);
        rd_reg(3, v); check("R5 upper imm bits ignored", v, 32'd96);
        rd_reg(4, v); check("R5 shift by 31", v, 32'h8000_0000);
        rd_reg(0, v); check("R7 r0 stays zero", v, 32'd0);
        rd_reg(5, v); check("R7 r0 source reads zero", v, 32'd3);
        rd_reg(6, v); check("R9 shift of prior result", v, 32'd30);
    endtask

    task automatic t_noop();
        logic [31:0] v;
        do_reset(); clear_mems();
        put(1, 0, 32'd5); put(1, 1, 32'h55);
        put(0, 0, enc(6'h01, 0, 0, 1, 0));
        put(0, 1, enc(6'h00, 1, 1, 1, 1));
        put(0, 2, enc(6'h3F, 1, 1, 1, 1));
        put(0, 3, enc(6'h04, 0, 1, 1, 1));
        put(0, 4, enc(6'h22, 0, 1, 1, 1));
        run(5);
        check("R2 pc after 5 steps", pc, 32'd20);
        rd_reg(1, v); check("R6 register untouched", v, 32'd5);
        rd_mem(0, v); check("R6 word0 untouched", v, 32'd5);
        rd_mem(1, v); check("R6 word1 untouched", v, 32'h55);
    endtask

    task automatic t_decode();
        do_reset();
        put(0, 0, enc(6'h01, 1, 2, 3, 0)); #1;
        check("R8 load-and-add controls", {29'd0, ctl_reg_we, ctl_mem_we, ctl_mem_re}, 32'b101);
        put(0, 0, enc(6'h02, 1, 2, 3, 0)); #1;
        check("R8 add-and-store controls", {29'd0, ctl_reg_we, ctl_mem_we, ctl_mem_re}, 32'b010);
        put(0, 0, enc(6'h03, 1, 2, 3, 0)); #1;
        check("R8 shift-and-add controls", {29'd0, ctl_reg_we, ctl_mem_we, ctl_mem_re}, 32'b100);
        put(0, 0, enc(6'h00, 1, 2, 3, 0)); #1;
        check("R8 opcode 0 controls", {29'd0, ctl_reg_we, ctl_mem_we, ctl_mem_re}, 32'b000);
        put(0, 0, enc(6'h3F, 1, 2, 3, 0)); #1;
        check("R8 opcode 3F controls", {29'd0, ctl_reg_we, ctl_mem_we, ctl_mem_re}, 32'b000);
    endtask

    task automatic t_freeze();
        logic [31:0] v;
        do_reset(); clear_mems();
        put(1, 0, 32'd9);
        put(0, 0, enc(6'h01, 0, 0, 1, 0));
        put(0, 1, enc(6'h02, 0, 1, 0, 11'd1));
        run(1);
        check("R2 pc after one step", pc, 32'd4);
        repeat (5) @(negedge clk);
        put(1, 5, 32'hABC);
        #1; check("R10 pc held while loading", pc, 32'd4);
        rd_mem(0, v); check("R10 store suppressed", v, 32'd9);
        rd_mem(5, v); check("R10 load port write", v, 32'hABC);
        run(1);
        rd_mem(0, v); check("R4 store after release", v, 32'd10);
        check("R2 pc after release", pc, 32'd8);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; load_en = 1'b1; load_to_dmem = 1'b0;
        load_word = '0; load_data = '0; peek_reg = '0; peek_word = '0;
        t_ldadd();
        t_reset();
        t_addst();
        t_shadd();
        t_noop();
        t_decode();
        t_freeze();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule